// File: doc/BRIEF.md
# Slave-Serial FPGA Configuration Sequencer

This block loads a downstream FPGA through its slave-serial configuration port. A start request moves it from idle through a fixed sequence. It drives the program pin low for a set number of clock cycles and then releases it. It polls the target's init-ready line at a fixed interval until the line reads high. It then takes configuration bytes one at a time from a valid/ready stream and shifts each byte out, most significant bit first, on a data pin and a configuration clock. After the last byte it keeps toggling the configuration clock until the target raises its done line.

The number of bytes to send is sampled from an input at start. Both waits are bounded: a fixed number of init polls, and a fixed number of trailing clock pulses. Running out of either bound ends the run with an error. A failure flag from the byte source also ends the run with an error. Busy covers the whole run. Success or error then stays set until the next start.

Top module: `cfg_serial_loader`

## Requirements
- R1: During and after reset, and whenever idle, the program pin is high, the configuration clock is low and busy is low. Success, error and byte_ready are also low after reset, and the data pin is low.
- R2: A start seen while idle clears success and error, raises busy, and drives the program pin low for exactly PROG_LOW_CYC cycles before it returns high.
- R3: After release, init is sampled every POLL_CYC cycles. If INIT_POLLS samples in a row read low, the run ends with error set, busy low, and no configuration clock pulse.
- R4: Each byte goes out bit 7 first and bit 0 last. For every bit the data pin is set while the clock is low, the clock is low for at least HALF_CYC cycles and high for exactly HALF_CYC cycles, and the data pin does not change while the clock is high.
- R5: byte_ready is high only between bytes, after bit 0 of the previous byte has been clocked, and never while the clock is high. Exactly byte_len_i bytes are accepted; any further bytes the source offers are left untaken.
- R6: With a length of zero, no byte is requested, and the block moves from the init wait straight to trailing clocks.
- R7: After the data, done is sampled HALF_CYC cycles into each low clock phase, starting before the first extra pulse. A high sample ends the run with success, and no further pulse is issued.
- R8: If done is still low after DONE_PULSES extra pulses, the run ends with error.
- R9: A byte-source failure seen while a byte is awaited ends the run with error, with the configuration clock left low. The failure takes priority over a valid byte in the same cycle.
- R10: A start request while busy is ignored, and the ongoing run is unaffected.
- R11: Success and error are never both high, and exactly one of them is high when busy falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a configuration run (taken only while idle) |
| byte_len_i | input | LEN_W | Number of configuration bytes, sampled at start |
| byte_data_i | input | 8 | Configuration byte from the source |
| byte_valid_i | input | 1 | Source offers byte_data_i |
| byte_err_i | input | 1 | Source reports a failure |
| byte_ready_o | output | 1 | Block accepts a byte this cycle |
| init_i | input | 1 | Target init-ready line (high = ready) |
| done_i | input | 1 | Target configuration-done line |
| prog_o | output | 1 | Target program pin (low pulse starts configuration) |
| cclk_o | output | 1 | Configuration clock to target |
| dout_o | output | 1 | Configuration data to target |
| busy_o | output | 1 | Run in progress |
| success_o | output | 1 | Last run ended with done seen |
| error_o | output | 1 | Last run ended by a timeout or source failure |

## Verification
The properties assume that start, the stream inputs and the target lines change only between clock edges, and that reset is held for at least one edge at power-up. They also assume a run is never started from inside reset. The stimulus drives every input on the falling edge. It models the target's init and done lines as reactions to the block's own program pin and clock edges. The byte source pauses in a fixed pattern, and its failure flag is raised only after a chosen number of bytes has been taken. This keeps every handshake inside the valid/ready rules the block relies on.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROG,
        ST_WAIT_INIT,
        ST_FETCH,
        ST_SHIFT_LO,
        ST_SHIFT_HI,
        ST_FLUSH_LO,
        ST_FLUSH_HI
    } cfgl_state_e;

    // Control strobes the sequencer hands to its datapath pieces each cycle.
    typedef struct packed {
        logic tick_clr;
        logic ev_clr;
        logic ev_inc;
        logic sh_clr;
        logic sh_load;
        logic sh_shift;
        logic rem_load;
        logic rem_dec;
    } cfgl_ctrl_t;

    // Registered pin and status values.
    typedef struct packed {
        logic prog;
        logic cclk;
        logic busy;
        logic success;
        logic error;
    } cfgl_pins_t;

    localparam cfgl_pins_t PINS_RESET = '{prog: 1'b1, cclk: 1'b0, busy: 1'b0,
                                          success: 1'b0, error: 1'b0};

    function automatic int cfgl_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/cfgl_tick.sv
// Cycle counter: restarts on clear or when it reaches its programmed last count.
module cfgl_tick #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic [W-1:0] last,
    output logic         hit
);
    logic [W-1:0] cnt_q;

    assign hit = (cnt_q == last);

    always_ff @(posedge clk) begin
        if (rst || clr || hit) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/cfgl_evcnt.sv
// Event counter for init polls and trailing clock pulses.
module cfgl_evcnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/cfgl_shifter.sv
// Byte shifter: presents bit 7 first, moves one place per shift, flags bit 0.
module cfgl_shifter (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       load,
    input  logic       shift,
    input  logic [7:0] din,
    output logic       bit_o,
    output logic       last_o
);
    logic [7:0] data_q;
    logic [2:0] idx_q;

    assign bit_o  = data_q[7];
    assign last_o = (idx_q == 3'd7);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            data_q <= '0;
            idx_q  <= '0;
        end else if (load) begin
            data_q <= din;
            idx_q  <= '0;
        end else if (shift) begin
            data_q <= {data_q[6:0], 1'b0};
            idx_q  <= idx_q + 3'd1;
        end
    end
endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
    import cfgl_pkg::*;
#(
    parameter int LEN_W        = 16,
    parameter int PROG_LOW_CYC = 16,
    parameter int POLL_CYC     = 4,
    parameter int HALF_CYC     = 1,
    parameter int INIT_POLLS   = 100000,
    parameter int DONE_PULSES  = 100000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [LEN_W-1:0] byte_len_i,
    input  logic [7:0]       byte_data_i,
    input  logic             byte_valid_i,
    input  logic             byte_err_i,
    output logic             byte_ready_o,
    input  logic             init_i,
    input  logic             done_i,
    output logic             prog_o,
    output logic             cclk_o,
    output logic             dout_o,
    output logic             busy_o,
    output logic             success_o,
    output logic             error_o
);
    localparam int TK_W = $clog2(cfgl_max(cfgl_max(PROG_LOW_CYC, POLL_CYC), HALF_CYC) + 1);
    localparam int EV_W = $clog2(cfgl_max(INIT_POLLS, DONE_PULSES) + 1);
    localparam logic [TK_W-1:0] PROG_LAST = TK_W'(PROG_LOW_CYC - 1);
    localparam logic [TK_W-1:0] POLL_LAST = TK_W'(POLL_CYC - 1);
    localparam logic [TK_W-1:0] HALF_LAST = TK_W'(HALF_CYC - 1);
    localparam logic [EV_W-1:0] INIT_LAST = EV_W'(INIT_POLLS - 1);
    localparam logic [EV_W-1:0] DONE_LIM  = EV_W'(DONE_PULSES);

    cfgl_state_e      st_q, st_n;
    cfgl_pins_t       pin_q, pin_n;
    cfgl_ctrl_t       ctl;
    logic [TK_W-1:0]  tick_last;
    logic             tick_hit;
    logic [EV_W-1:0]  ev_cnt;
    logic             sh_bit, sh_last;
    logic [LEN_W-1:0] rem_q;
    logic             rem_zero;

    assign rem_zero = (rem_q == '0);

    always_comb begin
        unique case (st_q)
            ST_PROG:      tick_last = PROG_LAST;
            ST_WAIT_INIT: tick_last = POLL_LAST;
            default:      tick_last = HALF_LAST;
        endcase
    end

    cfgl_tick #(.W(TK_W)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .clr  (ctl.tick_clr),
        .last (tick_last),
        .hit  (tick_hit)
    );

    cfgl_evcnt #(.W(EV_W)) u_evcnt (
        .clk (clk),
        .rst (rst),
        .clr (ctl.ev_clr),
        .inc (ctl.ev_inc),
        .cnt (ev_cnt)
    );

    cfgl_shifter u_shift (
        .clk    (clk),
        .rst    (rst),
        .clr    (ctl.sh_clr),
        .load   (ctl.sh_load),
        .shift  (ctl.sh_shift),
        .din    (byte_data_i),
        .bit_o  (sh_bit),
        .last_o (sh_last)
    );

    // Sequencer: next state, next pin values and datapath strobes.
    always_comb begin
        st_n         = st_q;
        pin_n        = pin_q;
        ctl          = '0;
        ctl.tick_clr = (st_q == ST_IDLE) || (st_q == ST_FETCH);
        unique case (st_q)
            ST_IDLE: begin
                if (start_i) begin
                    st_n          = ST_PROG;
                    pin_n.prog    = 1'b0;
                    pin_n.cclk    = 1'b0;
                    pin_n.busy    = 1'b1;
                    pin_n.success = 1'b0;
                    pin_n.error   = 1'b0;
                    ctl.rem_load  = 1'b1;
                    ctl.sh_clr    = 1'b1;
                    ctl.ev_clr    = 1'b1;
                end
            end
            ST_PROG: begin
                if (tick_hit) begin
                    pin_n.prog = 1'b1;
                    st_n       = ST_WAIT_INIT;
                end
            end
            ST_WAIT_INIT: begin
                if (tick_hit) begin
                    if (init_i) begin
                        ctl.ev_clr = 1'b1;
                        st_n       = rem_zero ? ST_FLUSH_LO : ST_FETCH;
                    end else if (ev_cnt == INIT_LAST) begin
                        st_n        = ST_IDLE;
                        pin_n.busy  = 1'b0;
                        pin_n.cclk  = 1'b0;
                        pin_n.error = 1'b1;
                    end else begin
                        ctl.ev_inc = 1'b1;
                    end
                end
            end
            ST_FETCH: begin
                if (byte_err_i) begin
                    st_n        = ST_IDLE;
                    pin_n.busy  = 1'b0;
                    pin_n.cclk  = 1'b0;
                    pin_n.error = 1'b1;
                end else if (byte_valid_i) begin
                    ctl.sh_load = 1'b1;
                    ctl.rem_dec = 1'b1;
                    st_n        = ST_SHIFT_LO;
                end
            end
            ST_SHIFT_LO: begin
                if (tick_hit) begin
                    pin_n.cclk = 1'b1;
                    st_n       = ST_SHIFT_HI;
                end
            end
            ST_SHIFT_HI: begin
                if (tick_hit) begin
                    pin_n.cclk = 1'b0;
                    if (sh_last) begin
                        ctl.ev_clr = 1'b1;
                        st_n       = rem_zero ? ST_FLUSH_LO : ST_FETCH;
                    end else begin
                        ctl.sh_shift = 1'b1;
                        st_n         = ST_SHIFT_LO;
                    end
                end
            end
            ST_FLUSH_LO: begin
                if (tick_hit) begin
                    if (done_i) begin
                        st_n          = ST_IDLE;
                        pin_n.busy    = 1'b0;
                        pin_n.success = 1'b1;
                    end else if (ev_cnt == DONE_LIM) begin
                        st_n        = ST_IDLE;
                        pin_n.busy  = 1'b0;
                        pin_n.error = 1'b1;
                    end else begin
                        pin_n.cclk = 1'b1;
                        ctl.ev_inc = 1'b1;
                        st_n       = ST_FLUSH_HI;
                    end
                end
            end
            ST_FLUSH_HI: begin
                if (tick_hit) begin
                    pin_n.cclk = 1'b0;
                    st_n       = ST_FLUSH_LO;
                end
            end
            default: st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            pin_q <= PINS_RESET;
            rem_q <= '0;
        end else begin
            st_q  <= st_n;
            pin_q <= pin_n;
            if (ctl.rem_load) begin
                rem_q <= byte_len_i;
            end else if (ctl.rem_dec) begin
                rem_q <= rem_q - 1'b1;
            end
        end
    end

    assign byte_ready_o = (st_q == ST_FETCH);
    assign prog_o       = pin_q.prog;
    assign cclk_o       = pin_q.cclk;
    assign dout_o       = sh_bit;
    assign busy_o       = pin_q.busy;
    assign success_o    = pin_q.success;
    assign error_o      = pin_q.error;

endmodule

// File: rtl/cfgl_checker.sv
module cfgl_checker (
    input logic clk,
    input logic rst,
    input logic start_i,
    input logic byte_ready_o,
    input logic prog_o,
    input logic cclk_o,
    input logic dout_o,
    input logic busy_o,
    input logic success_o,
    input logic error_o
);
    AST_RESET_PINS: assert property (@(posedge clk)
        rst |=> (prog_o && !cclk_o && !dout_o && !busy_o && !byte_ready_o)); // R1

    AST_IDLE_PINS: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (prog_o && !cclk_o && !byte_ready_o)); // R1

    AST_START_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> (busy_o && !prog_o && !success_o && !error_o)); // R2

    AST_DATA_HELD_HIGH: assert property (@(posedge clk) disable iff (rst)
        (cclk_o && $past(cclk_o)) |-> $stable(dout_o)); // R4

    AST_CLOCK_NEEDS_PROG: assert property (@(posedge clk) disable iff (rst)
        cclk_o |-> prog_o); // R4

    AST_NO_READY_CLK_HIGH: assert property (@(posedge clk) disable iff (rst)
        cclk_o |-> !byte_ready_o); // R5

    AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(success_o && error_o)); // R11

    AST_END_VERDICT: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> (success_o ^ error_o)); // R11
endmodule

bind cfg_serial_loader cfgl_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .byte_ready_o (byte_ready_o),
    .prog_o       (prog_o),
    .cclk_o       (cclk_o),
    .dout_o       (dout_o),
    .busy_o       (busy_o),
    .success_o    (success_o),
    .error_o      (error_o)
);

// File: tb/tb_cfg_serial_loader.sv
`timescale 1ns/1ps
module tb_cfg_serial_loader;
    localparam int CLK_PERIOD = 10;
    localparam int LEN_W = 16;
    localparam int PLOW  = 6;
    localparam int POLL  = 3;
    localparam int HALF  = 2;
    localparam int IPOLL = 20;
    localparam int DPULS = 30;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0;
    logic [LEN_W-1:0] byte_len_i = '0;
    logic [7:0] byte_data_i = '0;
    logic byte_valid_i = 1'b0;
    logic byte_err_i = 1'b0;
    logic init_i = 1'b0;
    logic done_i = 1'b0;
    logic byte_ready_o, prog_o, cclk_o, dout_o, busy_o, success_o, error_o;

    cfg_serial_loader #(
        .LEN_W(LEN_W), .PROG_LOW_CYC(PLOW), .POLL_CYC(POLL), .HALF_CYC(HALF),
        .INIT_POLLS(IPOLL), .DONE_PULSES(DPULS)
    ) dut (
        .clk(clk), .rst(rst), .start_i(start_i), .byte_len_i(byte_len_i),
        .byte_data_i(byte_data_i), .byte_valid_i(byte_valid_i), .byte_err_i(byte_err_i),
        .byte_ready_o(byte_ready_o), .init_i(init_i), .done_i(done_i),
        .prog_o(prog_o), .cclk_o(cclk_o), .dout_o(dout_o), .busy_o(busy_o),
        .success_o(success_o), .error_o(error_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    int ncyc = 0;

    // Environment settings and observations
    logic [7:0] byte_q[$];
    logic       bits_q[$];
    int  popped = 0, rises = 0, prog_low = 0, icnt = 100000;
    bit  gap_mode = 0, err_en = 0, init_en = 1, done_en = 1, pend = 0;
    int  err_after = 0, init_dly = 0, done_after = 0;
    logic cclk_prev = 1'b0;

    // Expected outputs from the reference model
    logic e_prog = 1, e_cclk = 0, e_dout = 0, e_busy = 0, e_succ = 0, e_err = 0, e_rdy = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Behavioural reference: walks the configuration sequence one edge at a time.
    initial begin : model
        logic [7:0] b;
        bit fin;
        int pulses;
        forever begin
            do @(posedge clk); while (!(start_i && !rst));
            e_prog = 0; e_busy = 1; e_succ = 0; e_err = 0; e_cclk = 0; e_dout = 0;
            repeat (PLOW) @(posedge clk);
            e_prog = 1;
            fin = 0;
            for (int i = 0; i < IPOLL; i++) begin
                repeat (POLL) @(posedge clk);
                if (init_i) begin fin = 1; break; end
            end
            if (!fin) begin
                e_busy = 0; e_err = 1;
                continue;
            end
            fin = 0;
            for (int n = 0; n < int'(byte_len_i); n++) begin
                e_rdy = 1;
                forever begin
                    @(posedge clk);
                    if (byte_err_i) begin fin = 1; break; end
                    if (byte_valid_i) begin b = byte_data_i; break; end
                end
                e_rdy = 0;
                if (fin) break;
                for (int k = 7; k >= 0; k--) begin
                    e_dout = b[k];
                    repeat (HALF) @(posedge clk);
                    e_cclk = 1;
                    repeat (HALF) @(posedge clk);
                    e_cclk = 0;
                end
            end
            if (fin) begin
                e_busy = 0; e_err = 1;
                continue;
            end
            pulses = 0;
            forever begin
                repeat (HALF) @(posedge clk);
                if (done_i) begin e_busy = 0; e_succ = 1; break; end
                if (pulses == DPULS) begin e_busy = 0; e_err = 1; break; end
                e_cclk = 1; pulses++;
                repeat (HALF) @(posedge clk);
                e_cclk = 0;
            end
        end
    end

    // Cycle-by-cycle comparison, byte source and target emulation, all on the falling edge.
    always @(negedge clk) begin
        ncyc++;
        if (!rst) begin
            chk("R2", "prog_o", prog_o, e_prog);
            chk("R4", "cclk_o", cclk_o, e_cclk);
            chk("R4", "dout_o", dout_o, e_dout);
            chk("R5", "byte_ready_o", byte_ready_o, e_rdy);
            chk("R10", "busy_o", busy_o, e_busy);
            chk("R7", "success_o", success_o, e_succ);
            chk("R9", "error_o", error_o, e_err);
        end
        if (pend) begin
            void'(byte_q.pop_front());
            popped++;
        end
        byte_err_i = err_en && (popped >= err_after);
        if (!byte_err_i && byte_q.size() > 0 && !(gap_mode && (ncyc % 3 == 0))) begin
            byte_valid_i = 1'b1;
            byte_data_i  = byte_q[0];
        end else begin
            byte_valid_i = 1'b0;
        end
        pend = byte_valid_i && byte_ready_o;
        if (!prog_o) begin
            icnt = 0;
            prog_low++;
        end else if (icnt < 100000) begin
            icnt++;
        end
        init_i = init_en && (icnt > init_dly);
        if (cclk_o && !cclk_prev) begin
            rises++;
            bits_q.push_back(dout_o);
        end
        cclk_prev = cclk_o;
        done_i = done_en && (rises >= done_after);
    end

    task automatic run(input int len, input bit ien, input int idly, input bit den,
                       input int dafter, input bit gaps, input bit een, input int eafter,
                       input bit mid_start);
        int n;
        @(negedge clk);
        #1;
        byte_len_i = LEN_W'(len);
        init_en = ien; init_dly = idly; done_en = den; done_after = dafter;
        gap_mode = gaps; err_en = een; err_after = eafter;
        popped = 0; rises = 0; prog_low = 0; pend = 0;
        bits_q.delete();
        start_i = 1'b1;
        @(negedge clk);
        #1;
        start_i = 1'b0;
        chk("R11", "success cleared at start", success_o, 0);
        chk("R11", "error cleared at start", error_o, 0);
        n = 0;
        while (busy_o && n < 5000) begin
            @(negedge clk);
            #1;
            n++;
            start_i = (mid_start && n == 20);
        end
        start_i = 1'b0;
        chk("R10", "run finished within bound", int'(n < 5000), 1);
        chk("R2", "program low cycles", prog_low, PLOW);
        err_en = 0;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        logic [7:0] exp_bytes[$];
        repeat (3) @(negedge clk);
        #1;
        chk("R1", "reset prog", prog_o, 1);
        chk("R1", "reset cclk", cclk_o, 0);
        chk("R1", "reset dout", dout_o, 0);
        chk("R1", "reset busy", busy_o, 0);
        chk("R1", "reset status", {success_o, error_o, byte_ready_o}, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // Normal load, one byte more in the source than requested
        exp_bytes = '{8'hA5, 8'h3C, 8'h81};
        byte_q = '{8'hA5, 8'h3C, 8'h81, 8'h77};
        run(3, 1, 4, 1, 24 + 5, 0, 0, 0, 0);
        chk("R7", "success after done", success_o, 1);
        chk("R7", "clock rises incl. trailing", rises, 29);
        chk("R5", "bytes taken", popped, 3);
        chk("R5", "byte left in source", byte_q.size(), 1);
        for (int i = 0; i < 24; i++)
            chk("R4", "bit order msb first", bits_q[i], exp_bytes[i / 8][7 - (i % 8)]);
        byte_q.delete();

        // Gapped source, done already high, start pulsed mid-run
        byte_q = '{8'h0F, 8'hF0};
        run(2, 1, 0, 1, 16, 1, 0, 0, 1);
        chk("R7", "no extra pulse when done already high", rises, 16);
        chk("R10", "mid-run start ignored: bytes taken", popped, 2);
        chk("R10", "mid-run start ignored: success", success_o, 1);
        for (int i = 0; i < 8; i++)
            chk("R4", "bit pattern 0F", bits_q[i], int'(i >= 4));

        // Zero length
        byte_q = '{8'hEE};
        run(0, 1, 2, 1, 3, 0, 0, 0, 0);
        chk("R6", "zero length pulses", rises, 3);
        chk("R6", "zero length takes no byte", popped, 0);
        chk("R6", "zero length success", success_o, 1);
        byte_q.delete();

        // Init never rises
        byte_q = '{8'h12};
        run(1, 0, 0, 1, 0, 0, 0, 0, 0);
        chk("R3", "init timeout error", error_o, 1);
        chk("R3", "no clock on init timeout", rises, 0);
        chk("R3", "no byte on init timeout", popped, 0);
        byte_q.delete();

        // Done never rises
        byte_q = '{8'h55};
        run(1, 1, 1, 0, 0, 0, 0, 0, 0);
        chk("R8", "done timeout error", error_o, 1);
        chk("R8", "pulses before timeout", rises, 8 + DPULS);
        chk("R11", "no success on timeout", success_o, 0);

        // Source failure after the first byte
        byte_q = '{8'hC3, 8'h11, 8'h22, 8'h33};
        run(4, 1, 1, 1, 100, 0, 1, 1, 0);
        chk("R9", "source failure error", error_o, 1);
        chk("R9", "only first byte clocked", rises, 8);
        chk("R9", "clock low after failure", cclk_o, 0);
        chk("R9", "bytes taken before failure", popped, 1);
        byte_q.delete();

        repeat (4) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule